// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns a single asynchronous serial line into parallel bytes. It runs from a fast system clock and divides it down to a sampling tick at twelve times the line rate. It resynchronises to every incoming start bit, so a small mismatch between the local divider and the far-end transmitter affects only the current frame. Errors do not carry over from one frame to the next.

The line passes through a two-flop synchroniser first. The receiver arms only after it has seen a run of high idle samples. A low sample after that run opens a frame, and the frame's bit windows are then counted from that sample. Each bit is decided by a majority vote over its twelve samples, which makes the receiver tolerant of short glitches. A frame with a good stop bit produces a one-cycle valid strobe and the received byte. A frame whose stop bit is low produces a one-cycle framing-error strobe instead. In that case the receiver waits for the line to go high before it arms again.

Top module: `uart_os_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `valid_o` and `ferr_o` are 0 and `data_o` is 0 until the first good frame.
- R2: A frame has one low start bit, then 8 data bits sent least significant bit first, then one high stop bit. A frame with a good stop bit makes `valid_o` high for exactly one cycle. `data_o` then holds the byte until the next good frame.
- R3: A bit is read as 1 when more than 6 of its 12 samples are high, and as 0 otherwise. So 6 high samples give a 0, and 7 high samples give a 1.
- R4: A start bit is accepted only when a low sample follows at least `IDLE_RUN` (default 8) consecutive high samples. A line that goes low after a shorter high run produces neither `valid_o` nor `ferr_o`.
- R5: If the start-bit window does not vote low, the receiver returns to idle without asserting `valid_o` or `ferr_o`. The next proper frame is then received correctly.
- R6: If the stop-bit window does not vote high, `ferr_o` is high for one cycle and `valid_o` stays low. The receiver waits for a high sample before it can arm again, and a later good frame is received correctly.
- R7: Bit timing restarts at each accepted start bit. Frames separated by one idle bit period are received correctly when the transmitter's bit period is off by up to about ±2% from nominal, in either direction, in any mix.
- R8: The sample tick period is `round(CLK_HZ / (BAUD*12))` system clocks. `valid_o` therefore rises between 119 and 120 tick periods (plus a few cycles of synchroniser latency) after the start edge on `rx_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | DATA_BITS | Last byte received with a good stop bit |
| valid_o | output | 1 | One-cycle strobe when a new byte is on `data_o` |
| ferr_o | output | 1 | One-cycle strobe when a frame ends with a low stop bit |

## Verification
The embedded assertions watch, on every cycle, that the valid and framing-error strobes last one cycle each. They also check that a valid strobe comes only out of the stop-bit phase, that a framing error always leaves the receiver waiting for a high line, and that the sampling tick never fires on two cycles in a row. Other behaviours need the bench's scenarios: the bit order, the exact majority threshold (six inverted samples flip a 1 but not a 0), rejection of short idle runs and false starts, and recovery after a framing error. The same holds for tolerance of ±2% transmitter skew over a long random run, and for the rounded divider, which the bench measures as the delay from the start edge to the valid strobe.

// File: rtl/uart_os_pkg.sv
// Shared definitions for the oversampling serial receiver.
// Assumes integer parameters small enough for 32-bit arithmetic.
package uart_os_pkg;

    // Receiver phases of a frame
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAITHI
    } rx_state_e;

    // Integer division rounded to the nearest whole number
    function automatic int div_round(input int num, input int den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/uart_os_sync.sv
// Multi-flop synchroniser for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module uart_os_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/uart_os_tick.sv
// Free-running divider producing a one-cycle sampling tick every DIV clocks.
// Assumes DIV >= 1; with DIV == 1 the tick is permanently high.
module uart_os_tick #(
    parameter int DIV = 868
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // Count system clocks and wrap at the end of a tick period
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == LAST);

    if (DIV > 1) begin : g_tick_chk
        // R8
        tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o);
    end

endmodule

// File: rtl/uart_os_vote.sv
// Per-bit sample counter and majority voter over OVS samples.
// Assumes restart_i coincides with the first (already low) sample of a frame.
module uart_os_vote #(
    parameter int OVS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic samp_en_i,
    input  logic samp_i,
    output logic bit_done_o,
    output logic bit_val_o
);

    localparam int SW = $clog2(OVS + 1);
    localparam logic [SW-1:0] LAST = SW'(OVS - 1);

    logic [SW-1:0] scnt;
    logic [SW-1:0] ones;
    logic [SW:0]   total;
    logic          last;

    assign last  = (scnt == LAST);
    assign total = {1'b0, ones} + {{SW{1'b0}}, samp_i};

    // Track sample position in the bit and the count of high samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scnt <= '0;
            ones <= '0;
        end else if (restart_i) begin
            scnt <= SW'(1);
            ones <= '0;
        end else if (samp_en_i) begin
            if (last) begin
                scnt <= '0;
                ones <= '0;
            end else begin
                scnt <= scnt + 1'b1;
                ones <= ones + {{(SW-1){1'b0}}, samp_i};
            end
        end
    end

    assign bit_done_o = samp_en_i && last;
    assign bit_val_o  = int'(total) > (OVS / 2);

endmodule

// File: rtl/uart_os_rx.sv
// Oversampling asynchronous serial receiver, 1 start, DATA_BITS data
// (LSB first), 1 stop bit, no parity. Assumes rx_i idles high and that the
// system clock is at least a few times faster than BAUD*OVS.
module uart_os_rx #(
    parameter int CLK_HZ    = 100_000_000,
    parameter int BAUD      = 9600,
    parameter int OVS       = 12,
    parameter int IDLE_RUN  = 8,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_i,
    output logic [DATA_BITS-1:0] data_o,
    output logic                 valid_o,
    output logic                 ferr_o
);

    import uart_os_pkg::*;

    localparam int DIV = div_round(CLK_HZ, BAUD * OVS);
    localparam int RW  = $clog2(IDLE_RUN + 1);
    localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [RW-1:0] RUN_MAX  = RW'(IDLE_RUN);
    localparam logic [BW-1:0] BIT_LAST = BW'(DATA_BITS - 1);

    rx_state_e            state;
    logic                 rxs;
    logic                 tick;
    logic [RW-1:0]        run_cnt;
    logic [BW-1:0]        bidx;
    logic [DATA_BITS-1:0] shreg;
    logic                 armed;
    logic                 start_hit;
    logic                 busy;
    logic                 bit_done;
    logic                 bit_val;

    uart_os_sync #(.STAGES(2)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rxs)
    );

    uart_os_tick #(.DIV(DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    assign armed     = (run_cnt >= RUN_MAX);
    assign start_hit = tick && (state == RX_IDLE) && armed && !rxs;
    assign busy      = (state == RX_START) || (state == RX_DATA) || (state == RX_STOP);

    uart_os_vote #(.OVS(OVS)) i_vote (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (start_hit),
        .samp_en_i  (tick && busy),
        .samp_i     (rxs),
        .bit_done_o (bit_done),
        .bit_val_o  (bit_val)
    );

    // Count consecutive high samples, saturating at the arming threshold
    always_ff @(posedge clk) begin
        if (!rst_n)                  run_cnt <= '0;
        else if (tick && !rxs)       run_cnt <= '0;
        else if (tick && !armed)     run_cnt <= run_cnt + 1'b1;
    end

    // Frame sequencer: start check, data shift, stop check, error wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            bidx    <= '0;
            shreg   <= '0;
            data_o  <= '0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (start_hit) state <= RX_START;
                end
                RX_START: begin
                    if (bit_done) begin
                        bidx  <= '0;
                        state <= bit_val ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (bit_done) begin
                        shreg <= {bit_val, shreg[DATA_BITS-1:1]};
                        if (bidx == BIT_LAST) state <= RX_STOP;
                        else                  bidx  <= bidx + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (bit_done) begin
                        if (bit_val) begin
                            data_o  <= shreg;
                            valid_o <= 1'b1;
                            state   <= RX_IDLE;
                        end else begin
                            ferr_o  <= 1'b1;
                            state   <= RX_WAITHI;
                        end
                    end
                end
                RX_WAITHI: begin
                    if (tick && rxs) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R2
    valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(state == RX_STOP));

    // R6
    ferr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_o |=> !ferr_o);

    // R6
    ferr_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ferr_o |-> (state == RX_WAITHI && !valid_o));

endmodule

// File: tb/test_uart_os_rx.sv
`timescale 1ns/1ps
module test_uart_os_rx;

    localparam int CLK_HZ  = 1_250_000;
    localparam int BAUD    = 9600;
    localparam int DIV_EXP = (2 * CLK_HZ + BAUD * 12) / (2 * BAUD * 12);
    localparam int BIT     = 12 * DIV_EXP;
    localparam int WD      = 190_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_i = 1'b0;
    logic [7:0] data_o;
    logic       valid_o;
    logic       ferr_o;

    int cyc = 0;
    int nval = 0;
    int nferr = 0;
    int ferr_cycles = 0;
    int t_valid = 0;
    int t_edge = 0;
    logic [7:0] last_byte = 8'h00;
    int nchk = 0;
    int nbad = 0;
    bit fin = 1'b0;

    uart_os_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_uart_os_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
        .data_o(data_o), .valid_o(valid_o), .ferr_o(ferr_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (valid_o) begin
            nval = nval + 1;
            last_byte = data_o;
            t_valid = cyc;
        end
        if (ferr_o) begin
            nferr = nferr + 1;
            ferr_cycles = ferr_cycles + 1;
        end
    end

    function automatic logic [9:0] frame_bits(input logic [7:0] b, input logic stop_v);
        return {stop_v, b, 1'b0};
    endfunction

    function automatic logic [7:0] exp_glitch(input logic [7:0] b, input int bi, input int ninv);
        logic [7:0] r = b;
        int highs = b[bi] ? (12 - ninv) : ninv;
        r[bi] = (highs > 6);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        rx_i = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input int per, input logic stop_v,
                              input int gbit, input int glen);
        logic [9:0] f = frame_bits(b, stop_v);
        t_edge = cyc;
        for (int k = 0; k < 10; k++) begin
            for (int c = 0; c < per; c++) begin
                rx_i = f[k];
                if (k == gbit + 1 && c >= per / 3 && c < per / 3 + glen) rx_i = ~f[k];
                @(negedge clk);
            end
        end
    endtask

    task automatic expect_byte(input string tag, input logic [7:0] e, input int nv0);
        chk(nval == nv0 + 1, {tag, " strobe count"}, nval, nv0 + 1);
        chk(last_byte == e, {tag, " byte"}, int'(last_byte), int'(e));
    endtask

    initial begin
        int nv;
        int nf;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(valid_o == 1'b0, "R1 valid", int'(valid_o), 0);
        chk(ferr_o == 1'b0, "R1 ferr", int'(ferr_o), 0);
        chk(data_o == 8'h00, "R1 data", int'(data_o), 0);
        rst_n = 1'b1;

        // R4: low from reset, short high run, low again, then idle
        repeat (300) @(negedge clk);
        rx_i = 1'b1;
        repeat (3 * DIV_EXP) @(negedge clk);
        rx_i = 1'b0;
        repeat (1500) @(negedge clk);
        idle(3 * BIT);
        chk(nval == 0, "R4 no valid after short idle run", nval, 0);
        chk(nferr == 0, "R4 no ferr after short idle run", nferr, 0);

        // R2 directed bytes, R8 latency on the first
        begin
            logic [7:0] dir [5] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h00};
            for (int i = 0; i < 5; i++) begin
                nv = nval;
                send_frame(dir[i], BIT, 1'b1, -1, 0);
                idle(2 * BIT);
                expect_byte("R2", dir[i], nv);
                if (i == 0) begin
                    chk((t_valid - t_edge) >= 119 * DIV_EXP && (t_valid - t_edge) <= 120 * DIV_EXP + 4,
                        "R8 start-to-valid delay", t_valid - t_edge, 120 * DIV_EXP);
                end
            end
        end

        // R3 majority threshold with in-bit glitches of 4, 6, 6 and 8 samples
        begin
            int gb [4] = '{3, 3, 2, 2};
            int gn [4] = '{4, 6, 6, 8};
            for (int i = 0; i < 4; i++) begin
                nv = nval;
                send_frame(8'h5A, BIT, 1'b1, gb[i], gn[i] * DIV_EXP);
                idle(2 * BIT);
                expect_byte("R3", exp_glitch(8'h5A, gb[i], gn[i]), nv);
            end
        end

        // R5 false start: short low pulse after idle
        nv = nval;
        nf = nferr;
        rx_i = 1'b0;
        repeat (3 * DIV_EXP) @(negedge clk);
        idle(2 * BIT);
        chk(nval == nv, "R5 no valid on false start", nval, nv);
        chk(nferr == nf, "R5 no ferr on false start", nferr, nf);
        send_frame(8'h3C, BIT, 1'b1, -1, 0);
        idle(2 * BIT);
        expect_byte("R5 after false start", 8'h3C, nv);

        // R6 framing error, line held low, then recovery
        nv = nval;
        nf = nferr;
        ferr_cycles = 0;
        send_frame(8'hC3, BIT, 1'b0, -1, 0);
        rx_i = 1'b0;
        repeat (3 * BIT) @(negedge clk);
        idle(2 * BIT);
        chk(nferr == nf + 1, "R6 ferr count", nferr, nf + 1);
        chk(ferr_cycles == 1, "R6 ferr one cycle", ferr_cycles, 1);
        chk(nval == nv, "R6 no valid on bad stop", nval, nv);
        send_frame(8'h96, BIT, 1'b1, -1, 0);
        idle(2 * BIT);
        expect_byte("R6 after framing error", 8'h96, nv);

        // R7 random bytes with skewed transmitter periods and short gaps
        for (int i = 0; i < 30; i++) begin
            automatic logic [7:0] b = 8'($urandom);
            automatic int per = BIT - 3 + 3 * int'($urandom_range(2, 0));
            automatic int gap = 1 + int'($urandom_range(2, 0));
            nv = nval;
            send_frame(b, per, 1'b1, -1, 0);
            idle(gap * BIT);
            expect_byte("R7 skewed frame", b, nv);
        end

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!fin) begin
            nchk++;
            nbad++;
            $display("FAIL R7 watchdog actual=%0d expected=done", WD);
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

endmodule